// File: doc/BRIEF.md
# Packet Page Allocator with Transmit, Completion and Receive Queues

This block tracks ownership of a small pool of packet buffer pages and keeps the queues through which those pages move between software, the transmit engine and the receive engine. A bitmask records which pages are in use. Three short queues hold page numbers: pages waiting to be sent, sent pages waiting for software to reclaim them, and received pages waiting for software to read them. A 3-bit command code, applied with a one-cycle strobe, asks the block to allocate, release, enqueue, drop or clear. The block also keeps an 8-bit interrupt status with an 8-bit mask and drives one interrupt line.

A transmit allocation that finds no free page is not lost. It stays pending, with the allocation result reading the failure code 0x80, and any later release of a page retries it. On completion of a transmission, a per-call auto-release input chooses what happens to the page: it is freed at once, or its number is posted to the completion queue for software to release. The block moves no frame data and contains no MAC logic.

Every command takes effect in one clock. When several events arrive in the same cycle, they are applied in this order: the receive request (judged on the state before the edge), then the transmit-done handshake, then the command, then the acknowledge, then the mask write. The fixed status bits are recomputed last.

Top module: `pkt_page_mgr`

## Requirements
- R1: An allocation takes the lowest-numbered free page and marks it used. When every page is used, the allocation fails, and a transmit allocation then leaves `alloc_result` at 0x80.
- R2: Command 1 (transmit allocate) first sets `alloc_result` to 0x80 and clears status bit 0x08. On success it loads the page number into `alloc_result` and sets bit 0x08.
- R3: Command 5 releases the page given on `pkt_num` when `pkt_num` < 4, and ignores any larger value. Any release made while `alloc_result` is 0x80 retries the pending transmit allocation, with the same effects as R2.
- R4: Command 6 appends `pkt_num` to the transmit pending queue. The command is ignored when `pkt_num` >= 4 or the queue already holds 4 entries. `tx_req_valid`/`tx_req_page` show the head of the queue.
- R5: A `tx_done` pulse removes the head of the pending queue. With `auto_release` = 1 the page is freed (this release can retry a pending allocation as in R3). Otherwise the page number is appended to the completion queue, which holds at most 4 entries.
- R6: Status bit 0x04 is set whenever the pending queue is empty. Status bit 0x02 is set whenever the completion queue is not empty.
- R7: An acknowledge clears the status bits given by `ack_data` & 0xD6. When `ack_data` bit 1 (0x02) is set and the completion queue is not empty, its head is removed.
- R8: A receive request is accepted, in the same cycle (`rx_accept`), only when a page is free and the receive queue holds fewer than 4 entries. The lowest free page (`rx_page`) is then marked used, appended to the receive queue, and status bit 0x01 is set. A rejected request changes nothing.
- R9: Command 3 removes the receive queue head, then sets bit 0x01 if entries remain or clears it if the queue is now empty. Command 4 first releases the head page and then removes it. Either command on an empty queue is ignored.
- R10: `rx_head` and `done_head` show the head of their queue, or 0x80 when that queue is empty.
- R11: Command 2 clears the page bitmask and all three queues and sets `alloc_result` to 0. Command 7 empties only the pending and completion queues.
- R12: A mask write loads `mask_data`. `irq` is high exactly when status AND mask is not zero.
- R13: After reset, `alloc_result` is 0, status is 0x04, the mask is 0, and all queues and pages are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code 0..7 |
| pkt_num | input | 8 | Packet number operand for commands 5 and 6 |
| auto_release | input | 1 | Free the page on transmit completion instead of posting it |
| tx_done | input | 1 | Transmit engine finished the pending head page |
| rx_req | input | 1 | Receive engine asks for a page |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_data | input | 8 | Acknowledge value |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | New interrupt mask |
| alloc_result | output | 8 | Last transmit allocation result, 0x80 while pending |
| tx_req_valid | output | 1 | Pending queue not empty |
| tx_req_page | output | 2 | Page at the pending queue head |
| done_head | output | 8 | Completion queue head or 0x80 |
| rx_head | output | 8 | Receive queue head or 0x80 |
| rx_accept | output | 1 | Receive request accepted this cycle |
| rx_page | output | 2 | Page granted to an accepted receive request |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |

## Verification
Allocation is exercised by filling the pool from empty and then releasing pages in an order other than the order of allocation. A design that did not pick the lowest free page, or that reused a page still in use, returns a different page number. Some releases are made while an allocation is pending and some while none is, so an unconditional retry shows up as a wrong result. Duplicate, out-of-range and queue-overflow enqueues are interleaved so that each ignored operation would move a different page number to a queue head. The receive-drop and drop-release commands are followed by a fresh allocation, whose page number shows which pages each command actually freed.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;

    typedef enum logic [2:0] {
        PCMD_NOP      = 3'd0,
        PCMD_TX_ALLOC = 3'd1,
        PCMD_RESET    = 3'd2,
        PCMD_RX_DROP  = 3'd3,
        PCMD_RX_FREE  = 3'd4,
        PCMD_RELEASE  = 3'd5,
        PCMD_TX_ENQ   = 3'd6,
        PCMD_TX_CLR   = 3'd7
    } pcmd_e;

    localparam logic [7:0] IRQ_RX       = 8'h01;
    localparam logic [7:0] IRQ_TXDONE   = 8'h02;
    localparam logic [7:0] IRQ_TXIDLE   = 8'h04;
    localparam logic [7:0] IRQ_ALLOC    = 8'h08;
    localparam logic [7:0] ACK_CLR_MASK = 8'hD6;
    localparam logic [7:0] NO_PAGE      = 8'h80;

endpackage

// File: rtl/pkt_page_pick.sv
module pkt_page_pick #(
    parameter int NUM_PAGES = 4,
    localparam int PG_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic [NUM_PAGES-1:0] used,
    output logic [PG_W-1:0]      free_idx,
    output logic                 all_used
);
    logic [NUM_PAGES-1:0] below_free;
    logic [NUM_PAGES-1:0] first;

    assign below_free[0] = 1'b0;
    generate
        for (genvar g = 1; g < NUM_PAGES; g++) begin : g_chain
            assign below_free[g] = below_free[g-1] | ~used[g-1];
        end
    endgenerate

    assign first    = ~used & ~below_free;
    assign all_used = &used;

    always_comb begin
        free_idx = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (first[i]) free_idx = free_idx | PG_W'(i);
        end
    end
endmodule

// File: rtl/pkt_page_irq.sv
module pkt_page_irq #(
    parameter int W = 8
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    output logic         line
);
    assign line = |(status & mask);
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
    import pkt_page_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    localparam int PG_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int LEN_W = $clog2(NUM_PAGES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic [7:0]      pkt_num,
    input  logic            auto_release,
    input  logic            tx_done,
    input  logic            rx_req,
    input  logic            ack_valid,
    input  logic [7:0]      ack_data,
    input  logic            mask_wr,
    input  logic [7:0]      mask_data,
    output logic [7:0]      alloc_result,
    output logic            tx_req_valid,
    output logic [PG_W-1:0] tx_req_page,
    output logic [7:0]      done_head,
    output logic [7:0]      rx_head,
    output logic            rx_accept,
    output logic [PG_W-1:0] rx_page,
    output logic [7:0]      int_status,
    output logic [7:0]      int_mask,
    output logic            irq
);
    localparam logic [LEN_W-1:0] QFULL  = LEN_W'(NUM_PAGES);
    localparam logic [LEN_W-1:0] LEN_1  = LEN_W'(1);
    localparam logic [7:0]       PG_LIM = 8'(NUM_PAGES);

    typedef logic [NUM_PAGES-1:0][PG_W-1:0] qarr_t;

    typedef struct packed {
        logic [NUM_PAGES-1:0] used;
        logic [7:0]           alloc_res;
        qarr_t                txq;
        logic [LEN_W-1:0]     txlen;
        qarr_t                dnq;
        logic [LEN_W-1:0]     dnlen;
        qarr_t                rxq;
        logic [LEN_W-1:0]     rxlen;
        logic [7:0]           stat;
        logic [7:0]           mask;
    } st_t;

    st_t st_q, st_d;

    // Queue head removal: every entry moves one place toward the head.
    function automatic qarr_t q_shift(qarr_t a);
        qarr_t r = a;
        for (int i = 0; i < NUM_PAGES - 1; i++) r[i] = a[i+1];
        return r;
    endfunction

    // Transmit allocation attempt on the given state.
    function automatic st_t try_tx_alloc(st_t x);
        st_t r = x;
        logic [PG_W-1:0] idx = '0;
        if (&x.used) begin
            r.alloc_res = NO_PAGE;
        end else begin
            for (int i = NUM_PAGES - 1; i >= 0; i--) begin
                if (!x.used[i]) idx = PG_W'(i);
            end
            r.used[idx] = 1'b1;
            r.alloc_res = 8'(idx);
            r.stat      = r.stat | IRQ_ALLOC;
        end
        return r;
    endfunction

    // Free a page and retry an allocation left pending.
    function automatic st_t free_page(st_t x, logic [PG_W-1:0] p);
        st_t r = x;
        r.used[p] = 1'b0;
        if (r.alloc_res == NO_PAGE) r = try_tx_alloc(r);
        return r;
    endfunction

    function automatic st_t rx_pop(st_t x);
        st_t r = x;
        if (x.rxlen != '0) begin
            r.rxq   = q_shift(x.rxq);
            r.rxlen = x.rxlen - LEN_1;
            if (r.rxlen != '0) r.stat = r.stat | IRQ_RX;
            else               r.stat = r.stat & ~IRQ_RX;
        end
        return r;
    endfunction

    logic [PG_W-1:0] pick_idx;
    logic            pick_full;

    pkt_page_pick #(.NUM_PAGES(NUM_PAGES)) pick_i (
        .used     (st_q.used),
        .free_idx (pick_idx),
        .all_used (pick_full)
    );

    logic rx_ok;
    assign rx_ok = rx_req && !pick_full && (st_q.rxlen != QFULL);

    always_comb begin
        st_t s;
        logic [PG_W-1:0] p;
        s = st_q;
        p = '0;

        // receive side request, judged on registered state
        if (rx_ok) begin
            s.used[pick_idx]                = 1'b1;
            s.rxq[s.rxlen[PG_W-1:0]]        = pick_idx;
            s.rxlen                         = s.rxlen + LEN_1;
            s.stat                          = s.stat | IRQ_RX;
        end

        // transmit completion handshake
        if (tx_done && s.txlen != '0) begin
            p       = s.txq[0];
            s.txq   = q_shift(s.txq);
            s.txlen = s.txlen - LEN_1;
            if (auto_release) begin
                s = free_page(s, p);
            end else if (s.dnlen != QFULL) begin
                s.dnq[s.dnlen[PG_W-1:0]] = p;
                s.dnlen                  = s.dnlen + LEN_1;
            end
        end

        if (cmd_valid) begin
            unique case (pcmd_e'(cmd_code))
                PCMD_NOP: ;
                PCMD_TX_ALLOC: begin
                    s.alloc_res = NO_PAGE;
                    s.stat      = s.stat & ~IRQ_ALLOC;
                    s           = try_tx_alloc(s);
                end
                PCMD_RESET: begin
                    s.used      = '0;
                    s.txlen     = '0;
                    s.dnlen     = '0;
                    s.rxlen     = '0;
                    s.alloc_res = 8'h00;
                end
                PCMD_RX_DROP: s = rx_pop(s);
                PCMD_RX_FREE: begin
                    if (s.rxlen != '0) s = free_page(s, s.rxq[0]);
                    s = rx_pop(s);
                end
                PCMD_RELEASE: begin
                    if (pkt_num < PG_LIM) s = free_page(s, pkt_num[PG_W-1:0]);
                end
                PCMD_TX_ENQ: begin
                    if (pkt_num < PG_LIM && s.txlen != QFULL) begin
                        s.txq[s.txlen[PG_W-1:0]] = pkt_num[PG_W-1:0];
                        s.txlen                  = s.txlen + LEN_1;
                    end
                end
                PCMD_TX_CLR: begin
                    s.txlen = '0;
                    s.dnlen = '0;
                end
                default: ;
            endcase
        end

        if (ack_valid) begin
            s.stat = s.stat & ~(ack_data & ACK_CLR_MASK);
            if (ack_data[1] && s.dnlen != '0) begin
                s.dnq   = q_shift(s.dnq);
                s.dnlen = s.dnlen - LEN_1;
            end
        end

        if (mask_wr) s.mask = mask_data;

        // level-type status bits follow queue occupancy
        if (s.txlen == '0) s.stat = s.stat | IRQ_TXIDLE;
        if (s.dnlen != '0) s.stat = s.stat | IRQ_TXDONE;

        st_d = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.stat      <= IRQ_TXIDLE;
            st_q.alloc_res <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    pkt_page_irq #(.W(8)) irq_i (
        .status (st_q.stat),
        .mask   (st_q.mask),
        .line   (irq)
    );

    assign alloc_result = st_q.alloc_res;
    assign tx_req_valid = (st_q.txlen != '0);
    assign tx_req_page  = st_q.txq[0];
    assign done_head    = (st_q.dnlen != '0) ? 8'(st_q.dnq[0]) : NO_PAGE;
    assign rx_head      = (st_q.rxlen != '0) ? 8'(st_q.rxq[0]) : NO_PAGE;
    assign rx_accept    = rx_ok;
    assign rx_page      = pick_idx;
    assign int_status   = st_q.stat;
    assign int_mask     = st_q.mask;
endmodule

// File: rtl/pkt_page_mgr_chk.sv
module pkt_page_mgr_chk #(
    parameter int NUM_PAGES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       rx_req,
    input logic [7:0] alloc_result,
    input logic       tx_req_valid,
    input logic [7:0] done_head,
    input logic [7:0] rx_head,
    input logic       rx_accept,
    input logic [7:0] int_status,
    input logic [7:0] int_mask,
    input logic       irq
);
    assert_result_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_result == 8'h80) || (alloc_result < 8'(NUM_PAGES)));

    assert_alloc_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd1) |=> (alloc_result == 8'h80) || int_status[3]);

    assert_idle_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req_valid |-> int_status[2]);

    assert_done_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_head != 8'h80) |-> int_status[1]);

    assert_accept_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> rx_req);

    assert_rx_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_head != 8'h80) |-> int_status[0]);

    assert_irq_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_mask != 8'h00));
endmodule

bind pkt_page_mgr pkt_page_mgr_chk #(.NUM_PAGES(NUM_PAGES)) chk_i (.*);

// File: tb/pkt_page_mgr_tb_top.sv
module pkt_page_mgr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [7:0] pkt_num = 8'd0;
    logic       auto_release = 1'b0;
    logic       tx_done = 1'b0;
    logic       rx_req = 1'b0;
    logic       ack_valid = 1'b0;
    logic [7:0] ack_data = 8'd0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_data = 8'd0;
    logic [7:0] alloc_result;
    logic       tx_req_valid;
    logic [1:0] tx_req_page;
    logic [7:0] done_head;
    logic [7:0] rx_head;
    logic       rx_accept;
    logic [1:0] rx_page;
    logic [7:0] int_status;
    logic [7:0] int_mask;
    logic       irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    logic       last_acc;
    logic [1:0] last_pg;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_page_mgr #(.NUM_PAGES(4)) dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] c, input logic [7:0] pn);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; pkt_num = pn;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] v);
        @(negedge clk);
        ack_valid = 1'b1; ack_data = v;
        @(posedge clk); #1;
        ack_valid = 1'b0;
    endtask

    task automatic do_mask(input logic [7:0] v);
        @(negedge clk);
        mask_wr = 1'b1; mask_data = v;
        @(posedge clk); #1;
        mask_wr = 1'b0;
    endtask

    task automatic do_txdone(input logic ar);
        @(negedge clk);
        tx_done = 1'b1; auto_release = ar;
        @(posedge clk); #1;
        tx_done = 1'b0;
    endtask

    task automatic do_rx();
        @(negedge clk);
        rx_req = 1'b1;
        #1;
        last_acc = rx_accept;
        last_pg  = rx_page;
        @(posedge clk); #1;
        rx_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R13", "alloc_result", alloc_result, 8'h00);
        check("R13", "int_status", int_status, 8'h04);
        check("R13", "irq", {7'd0, irq}, 8'h00);
        check("R10", "rx_head empty", rx_head, 8'h80);
        check("R10", "done_head empty", done_head, 8'h80);
        check("R13", "tx_req_valid", {7'd0, tx_req_valid}, 8'h00);
    endtask

    task automatic t_alloc();
        for (int i = 0; i < 4; i++) begin
            do_cmd(3'd1, 8'd0);
            check("R1", "alloc page", alloc_result, 8'(i));
            check("R2", "alloc flag", int_status & 8'h08, 8'h08);
        end
        do_cmd(3'd1, 8'd0);
        check("R1", "alloc when full", alloc_result, 8'h80);
        check("R2", "alloc flag cleared", int_status & 8'h08, 8'h00);
    endtask

    task automatic t_release();
        do_cmd(3'd5, 8'd9);
        check("R3", "invalid release ignored", alloc_result, 8'h80);
        do_cmd(3'd5, 8'd2);
        check("R3", "retry on release", alloc_result, 8'h02);
        check("R3", "retry sets flag", int_status & 8'h08, 8'h08);
        do_cmd(3'd5, 8'd1);
        check("R3", "no retry when not pending", alloc_result, 8'h02);
        do_cmd(3'd1, 8'd0);
        check("R1", "lowest free after release", alloc_result, 8'h01);
        do_cmd(3'd2, 8'd0);
        check("R11", "reset result", alloc_result, 8'h00);
    endtask

    task automatic t_tx();
        do_cmd(3'd1, 8'd0);
        check("R1", "alloc after reset", alloc_result, 8'h00);
        do_cmd(3'd6, 8'd0);
        check("R4", "enqueue valid", {7'd0, tx_req_valid}, 8'h01);
        check("R4", "head page", {6'd0, tx_req_page}, 8'h00);
        do_ack(8'h04);
        check("R6", "idle bit off while pending", int_status & 8'h04, 8'h00);
        do_cmd(3'd6, 8'd5);
        do_cmd(3'd6, 8'd0);
        do_cmd(3'd6, 8'd0);
        do_cmd(3'd6, 8'd0);
        do_cmd(3'd6, 8'd1);
        for (int i = 0; i < 4; i++) begin
            check("R4", "head before pop", {6'd0, tx_req_page}, 8'h00);
            do_txdone(1'b0);
        end
        check("R4", "queue drained (ignored enqueues)", {7'd0, tx_req_valid}, 8'h00);
        check("R6", "idle bit back", int_status & 8'h04, 8'h04);
        check("R5", "completion head", done_head, 8'h00);
        check("R6", "done bit", int_status & 8'h02, 8'h02);
        do_mask(8'h02);
        check("R12", "irq on masked bit", {7'd0, irq}, 8'h01);
        do_ack(8'h02);
        check("R7", "done bit persists", int_status & 8'h02, 8'h02);
        do_ack(8'h02); do_ack(8'h02); do_ack(8'h02);
        check("R7", "completion drained", done_head, 8'h80);
        check("R12", "irq low", {7'd0, irq}, 8'h00);
        do_ack(8'hFF);
        check("R7", "ack clears only 0xD6", int_status, 8'h0C);
        do_mask(8'h00);
    endtask

    task automatic t_autorel();
        do_cmd(3'd6, 8'd0);
        do_txdone(1'b1);
        check("R5", "auto release posts nothing", done_head, 8'h80);
        do_cmd(3'd1, 8'd0);
        check("R5", "auto released page reused", alloc_result, 8'h00);
    endtask

    task automatic t_rx();
        do_cmd(3'd2, 8'd0);
        do_rx();
        check("R8", "accept", {7'd0, last_acc}, 8'h01);
        check("R8", "grant page", {6'd0, last_pg}, 8'h00);
        check("R8", "rx head", rx_head, 8'h00);
        check("R8", "rx bit", int_status & 8'h01, 8'h01);
        do_rx();
        check("R8", "second grant", {6'd0, last_pg}, 8'h01);
        do_cmd(3'd3, 8'd0);
        check("R9", "drop head", rx_head, 8'h01);
        check("R9", "rx bit kept", int_status & 8'h01, 8'h01);
        do_cmd(3'd4, 8'd0);
        check("R9", "drop and free", rx_head, 8'h80);
        check("R9", "rx bit cleared", int_status & 8'h01, 8'h00);
        do_cmd(3'd3, 8'd0);
        check("R9", "empty drop ignored", rx_head, 8'h80);
        do_cmd(3'd1, 8'd0);
        check("R9", "cmd4 freed, cmd3 kept", alloc_result, 8'h01);
        do_rx(); do_rx();
        check("R8", "fill last page", {6'd0, last_pg}, 8'h03);
        do_rx();
        check("R8", "reject when no page", {7'd0, last_acc}, 8'h00);
        check("R8", "reject leaves queue", rx_head, 8'h02);
        do_cmd(3'd2, 8'd0);
        do_rx(); do_rx(); do_rx(); do_rx();
        do_cmd(3'd5, 8'd0);
        do_rx();
        check("R8", "reject when queue full", {7'd0, last_acc}, 8'h00);
        check("R8", "head after reject", rx_head, 8'h00);
    endtask

    task automatic t_clear();
        do_cmd(3'd2, 8'd0);
        do_cmd(3'd1, 8'd0);
        do_cmd(3'd6, 8'd0);
        do_cmd(3'd6, 8'd0);
        do_txdone(1'b0);
        do_rx();
        check("R8", "rx grant beside tx page", rx_head, 8'h01);
        do_cmd(3'd7, 8'd0);
        check("R11", "tx clear pending", {7'd0, tx_req_valid}, 8'h00);
        check("R11", "tx clear completion", done_head, 8'h80);
        check("R11", "tx clear keeps rx", rx_head, 8'h01);
        do_rx();
        check("R11", "tx clear keeps pages", {6'd0, last_pg}, 8'h02);
        do_cmd(3'd2, 8'd0);
        check("R11", "reset clears rx", rx_head, 8'h80);
        do_rx();
        check("R11", "reset frees pages", {6'd0, last_pg}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_alloc();
        t_release();
        t_tx();
        t_autorel();
        t_rx();
        t_clear();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule